// File: doc/BRIEF.md
# Predicated Execution Condition Checker

This block decides, one instruction at a time, whether that instruction is allowed to take effect. It holds the four arithmetic flags (negative, zero, carry, overflow) and a sticky saturation flag. Each instruction arrives with a 4-bit condition code, a request to update the flags, the flag values the ALU produced for it and a saturation indication. The block tests the condition against the flags it currently holds and reports an execute or skip decision in the same cycle.

Flags change only at the clock edge where an instruction is accepted, passes its condition and asks for an update. A skipped instruction leaves every piece of state untouched and occupies one accepted transfer, which is one cycle when the consumer is ready. Because the update lands at the edge, the very next instruction is tested against the new flags with no extra delay.

Instructions enter on a valid/ready issue port and leave as decisions on a valid/ready result port. The block adds no buffering: a decision is offered while an instruction is offered, and the issue side is ready exactly when the result side is ready. An instruction counts as accepted only in a cycle where both valid and ready are high, and back-pressure stalls every state change. Clearing the saturation flag is a plain control pin that software drives.

Top module: `cond_gate`

## Requirements
- R1: After reset, `flags_o` is 4'b0000 and `sat_o` is 0.
- R2: Single-flag tests, with `flags_o`/`iss_nzcv` bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V: code 0000 passes when Z=1, 0001 when Z=0, 0010 when C=1, 0011 when C=0, 0100 when N=1, 0101 when N=0, 0110 when V=1, 0111 when V=0.
- R3: Compound tests: code 1000 passes when C=1 and Z=0, 1001 when C=0 or Z=1, 1010 when N equals V, 1011 when N differs from V, 1100 when Z=0 and N equals V, 1101 when Z=1 or N differs from V.
- R4: Code 1110 always passes and code 1111 never passes, whatever the flags.
- R5: An accepted instruction that passes with `iss_setf` high loads `iss_nzcv` into the flags at that edge, and the following instruction is tested against the new flags.
- R6: An accepted instruction that fails its condition changes neither the flags nor the saturation flag, even with `iss_setf` or `iss_sat` high.
- R7: An accepted passing instruction with `iss_setf` low leaves the flags unchanged.
- R8: The saturation flag is set by an accepted passing instruction with `iss_sat` high, stays set across later instructions, and is cleared only by `clr_sat`; when a set and `clr_sat` coincide, the flag ends set.
- R9: `res_valid` follows `iss_valid` and `iss_ready` follows `res_ready`; in a cycle without both `iss_valid` and `res_ready` high, no state changes.
- R10: `res_exec` reflects the condition test of the offered instruction in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction is offered |
| iss_ready | output | 1 | The block accepts the offered instruction |
| iss_cond | input | 4 | Condition code of the instruction |
| iss_setf | input | 1 | Instruction asks to update the flags |
| iss_nzcv | input | 4 | Flag values produced by the ALU, {N,Z,C,V} |
| iss_sat | input | 1 | Instruction saturated |
| clr_sat | input | 1 | Clear the sticky saturation flag |
| res_valid | output | 1 | A decision is offered |
| res_ready | input | 1 | Consumer takes the decision |
| res_exec | output | 1 | 1 = execute, 0 = skip |
| flags_o | output | 4 | Current flags, {N,Z,C,V} |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
The decision logic is swept with every condition code against all sixteen flag combinations, which separates each code from its complement and from its neighbours in the compound group. Flags left by compares of operand pairs that are equal, ordered, reversed and overflowing in signed arithmetic tell apart not-equal, signed greater-than and signed less-than the way a loop built on them uses them. Back-to-back dependent instructions show that a fresh flag value is seen at once, while failing, non-updating and stalled instructions carrying all-ones flag values show that nothing leaks into state. Saturation set, hold, clear and set-over-clear sequences pin down the sticky behaviour.

// File: rtl/cond_gate_pkg.sv
package cond_gate_pkg;

  localparam int COND_W = 4;
  localparam int FLAG_W = 4;

  typedef enum logic [COND_W-1:0] {
    CC_ZSET  = 4'b0000,
    CC_ZCLR  = 4'b0001,
    CC_CSET  = 4'b0010,
    CC_CCLR  = 4'b0011,
    CC_NSET  = 4'b0100,
    CC_NCLR  = 4'b0101,
    CC_VSET  = 4'b0110,
    CC_VCLR  = 4'b0111,
    CC_UHI   = 4'b1000,
    CC_ULS   = 4'b1001,
    CC_SGE   = 4'b1010,
    CC_SLT   = 4'b1011,
    CC_SGT   = 4'b1100,
    CC_SLE   = 4'b1101,
    CC_ALWAYS= 4'b1110,
    CC_NEVER = 4'b1111
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

endpackage

// File: rtl/cond_eval.sv
module cond_eval
  import cond_gate_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  nzcv_t             flags_i,
  output logic              pass_o
);

  localparam int SEL_W = COND_W - 1;

  logic [SEL_W-1:0] base_sel;
  logic             invert;
  logic             base_ok;
  logic             n_eq_v;

  assign base_sel = cond_i[COND_W-1:1];
  assign invert   = cond_i[0];
  assign n_eq_v   = (flags_i.n == flags_i.v);

  // Even code of each pair holds the base test; the odd code inverts it.
  always_comb begin
    unique case (base_sel)
      3'd0:    base_ok = flags_i.z;
      3'd1:    base_ok = flags_i.c;
      3'd2:    base_ok = flags_i.n;
      3'd3:    base_ok = flags_i.v;
      3'd4:    base_ok = flags_i.c & ~flags_i.z;
      3'd5:    base_ok = n_eq_v;
      3'd6:    base_ok = ~flags_i.z & n_eq_v;
      default: base_ok = 1'b1;
    endcase
  end

  // The last pair is always / never, so its inversion is not XOR-ed with a flag.
  assign pass_o = (base_sel == 3'd7) ? ~invert : (base_ok ^ invert);

endmodule

// File: rtl/cond_flag_reg.sv
module cond_flag_reg
  import cond_gate_pkg::*;
#(
  parameter logic [FLAG_W-1:0] FLAG_RST = '0
)(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  upd_en,
  input  nzcv_t upd_val,
  input  logic  sat_set,
  input  logic  sat_clr,
  output nzcv_t flags_q,
  output logic  sat_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= nzcv_t'(FLAG_RST);
    end else if (upd_en) begin
      flags_q <= upd_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sat_q <= 1'b0;
    end else if (sat_set) begin
      sat_q <= 1'b1;
    end else if (sat_clr) begin
      sat_q <= 1'b0;
    end
  end

  // R7
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(flags_q));

  // R5
  flags_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> flags_q == $past(upd_val));

  // R8
  sat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_q && !sat_clr) |=> sat_q);

  // R8
  sat_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_set |=> sat_q);

endmodule

// File: rtl/cond_gate.sv
module cond_gate
  import cond_gate_pkg::*;
#(
  parameter logic [FLAG_W-1:0] FLAG_RST = '0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [COND_W-1:0] iss_cond,
  input  logic              iss_setf,
  input  logic [FLAG_W-1:0] iss_nzcv,
  input  logic              iss_sat,
  input  logic              clr_sat,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_exec,
  output logic [FLAG_W-1:0] flags_o,
  output logic              sat_o
);

  nzcv_t cur_flags;
  logic  cond_ok;
  logic  accepted;
  logic  do_upd;
  logic  do_sat;

  cond_eval u_eval (
    .cond_i  (iss_cond),
    .flags_i (cur_flags),
    .pass_o  (cond_ok)
  );

  assign accepted  = iss_valid & res_ready;
  assign do_upd    = accepted & cond_ok & iss_setf;
  assign do_sat    = accepted & cond_ok & iss_sat;

  assign res_valid = iss_valid;
  assign iss_ready = res_ready;
  assign res_exec  = cond_ok;

  cond_flag_reg #(.FLAG_RST(FLAG_RST)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (do_upd),
    .upd_val (nzcv_t'(iss_nzcv)),
    .sat_set (do_sat),
    .sat_clr (clr_sat),
    .flags_q (cur_flags),
    .sat_q   (sat_o)
  );

  assign flags_o = cur_flags;

  // R4
  always_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_cond == CC_ALWAYS) |-> res_exec);

  // R4
  never_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_cond == CC_NEVER) |-> !res_exec);

  // R6
  fail_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && !res_exec && !clr_sat) |=> ($stable(flags_o) && $stable(sat_o)));

  // R9
  stall_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(iss_valid && iss_ready) && !clr_sat) |=> ($stable(flags_o) && $stable(sat_o)));

  // R9
  handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid == iss_valid) && (iss_ready == res_ready));

endmodule

// File: tb/cond_gate_tb.sv
module cond_gate_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       iss_valid;
  logic       iss_ready;
  logic [3:0] iss_cond;
  logic       iss_setf;
  logic [3:0] iss_nzcv;
  logic       iss_sat;
  logic       clr_sat;
  logic       res_valid;
  logic       res_ready;
  logic       res_exec;
  logic [3:0] flags_o;
  logic       sat_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cond_gate u_dut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_cond(iss_cond), .iss_setf(iss_setf),
    .iss_nzcv(iss_nzcv), .iss_sat(iss_sat), .clr_sat(clr_sat),
    .res_valid(res_valid), .res_ready(res_ready), .res_exec(res_exec),
    .flags_o(flags_o), .sat_o(sat_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected decision, written code by code; flags are {N,Z,C,V}.
  function automatic logic want_pass(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, c, v;
    n = f[3]; z = f[2]; c = f[1]; v = f[0];
    case (cc)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return !c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic idle();
    iss_valid = 0; iss_cond = 4'he; iss_setf = 0;
    iss_nzcv = 0; iss_sat = 0; clr_sat = 0; res_ready = 1;
  endtask

  // Drive one instruction for one cycle, then return to idle after the edge.
  task automatic issue(input logic [3:0] cc, input logic setf, input logic [3:0] nv,
                       input logic sat, input logic rdy);
    @(negedge clk);
    iss_valid = 1; iss_cond = cc; iss_setf = setf;
    iss_nzcv = nv; iss_sat = sat; res_ready = rdy;
    @(posedge clk);
    #1 idle();
  endtask

  task automatic load_flags(input logic [3:0] nv);
    issue(4'he, 1'b1, nv, 1'b0, 1'b1);
  endtask

  task automatic t_reset();
    rst_n = 0; idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 flags", flags_o, 4'h0);
    check("R1 sat", sat_o, 1'b0);
  endtask

  task automatic t_sweep();
    for (int f = 0; f < 16; f++) begin
      load_flags(f[3:0]);
      @(negedge clk);
      check("R5 load", flags_o, f[3:0]);
      for (int cc = 0; cc < 16; cc++) begin
        iss_cond = cc[3:0];
        #2;
        if (cc < 8)       check("R2 decision", res_exec, want_pass(cc[3:0], f[3:0]));
        else if (cc < 14) check("R3 decision", res_exec, want_pass(cc[3:0], f[3:0]));
        else              check("R4 decision", res_exec, want_pass(cc[3:0], f[3:0]));
      end
      idle();
    end
  endtask

  // Flags a compare of a and b would leave: N, Z, C (no borrow), V.
  function automatic logic [3:0] cmp_flags(input logic [31:0] a, input logic [31:0] b);
    logic [32:0] d;
    logic        ov;
    d  = {1'b0, a} - {1'b0, b};
    ov = (a[31] != b[31]) && (d[31] != a[31]);
    return {d[31], d[31:0] == 0, !d[32], ov};
  endfunction

  task automatic t_compare();
    logic [31:0] av [5] = '{32'd7, 32'd3, 32'd5, 32'h8000_0000, 32'h7fff_ffff};
    logic [31:0] bv [5] = '{32'd3, 32'd7, 32'd5, 32'd1, 32'hffff_ffff};
    for (int i = 0; i < 5; i++) begin
      logic gt, lt, ne;
      gt = $signed(av[i]) > $signed(bv[i]);
      lt = $signed(av[i]) < $signed(bv[i]);
      ne = av[i] != bv[i];
      load_flags(cmp_flags(av[i], bv[i]));
      @(negedge clk);
      iss_cond = 4'b1100; #2 check("R3 signed greater", res_exec, gt);
      iss_cond = 4'b1011; #2 check("R3 signed less", res_exec, lt);
      iss_cond = 4'b0001; #2 check("R2 not equal", res_exec, ne);
      idle();
    end
  endtask

  task automatic t_back_to_back();
    load_flags(4'h0);
    @(negedge clk);
    iss_valid = 1; iss_cond = 4'he; iss_setf = 1; iss_nzcv = 4'b0100; res_ready = 1;
    @(posedge clk);
    @(negedge clk);
    iss_cond = 4'b0000; iss_setf = 0; iss_nzcv = 4'h0;
    #2 check("R5 next instruction sees Z", res_exec, 1'b1);
    check("R10 same-cycle decision valid", res_valid, 1'b1);
    iss_cond = 4'b0001;
    #2 check("R10 decision follows cond", res_exec, 1'b0);
    #1 idle();
  endtask

  task automatic t_fail_no_update();
    load_flags(4'h0);
    issue(4'b0000, 1'b1, 4'hf, 1'b1, 1'b1);
    @(negedge clk);
    check("R6 flags after failed", flags_o, 4'h0);
    check("R6 sat after failed", sat_o, 1'b0);
    issue(4'b1111, 1'b1, 4'hf, 1'b1, 1'b1);
    @(negedge clk);
    check("R4 never leaves flags", flags_o, 4'h0);
  endtask

  task automatic t_no_setf();
    load_flags(4'b1010);
    issue(4'he, 1'b0, 4'b0101, 1'b0, 1'b1);
    @(negedge clk);
    check("R7 flags kept", flags_o, 4'b1010);
  endtask

  task automatic t_stall();
    load_flags(4'h0);
    @(negedge clk);
    iss_valid = 1; iss_cond = 4'he; iss_setf = 1; iss_nzcv = 4'hf; iss_sat = 1; res_ready = 0;
    #2;
    check("R9 ready follows consumer", iss_ready, 1'b0);
    check("R9 valid follows issue", res_valid, 1'b1);
    @(posedge clk);
    @(negedge clk);
    check("R9 stalled flags", flags_o, 4'h0);
    check("R9 stalled sat", sat_o, 1'b0);
    res_ready = 1;
    #2 check("R9 ready released", iss_ready, 1'b1);
    @(posedge clk);
    #1 idle();
    @(negedge clk);
    check("R9 accepted after stall", flags_o, 4'hf);
    check("R8 sat from accepted", sat_o, 1'b1);
  endtask

  task automatic t_sticky();
    @(negedge clk); clr_sat = 1; @(posedge clk); #1 idle();
    @(negedge clk); check("R8 cleared", sat_o, 1'b0);
    issue(4'he, 1'b0, 4'h0, 1'b1, 1'b1);
    issue(4'he, 1'b1, 4'h0, 1'b0, 1'b1);
    issue(4'he, 1'b0, 4'h0, 1'b0, 1'b1);
    @(negedge clk); check("R8 held", sat_o, 1'b1);
    @(negedge clk); clr_sat = 1; @(posedge clk); #1 idle();
    @(negedge clk); check("R8 clear works", sat_o, 1'b0);
    @(negedge clk);
    iss_valid = 1; iss_cond = 4'he; iss_sat = 1; clr_sat = 1;
    @(posedge clk); #1 idle();
    @(negedge clk); check("R8 set wins over clear", sat_o, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sweep();
    t_compare();
    t_back_to_back();
    t_fail_no_update();
    t_no_setf();
    t_stall();
    t_sticky();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule